// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block holds the register map that sits behind a serial slave interface in a dual-channel digital potentiometer. It keeps a volatile wiper code per channel, a non-volatile start-up code per channel, a bank of general-purpose non-volatile bytes and one volatile control register. The control register decides whether the two lowest addresses reach the live wiper codes or the stored start-up codes, and it also holds a shutdown enable and the output-type bit for the serial data pin.

The serial slave presents one request per clock (valid, write flag, 5-bit address, data byte). One cycle later the block answers with an accept flag and, for accepted reads, the data byte. Non-volatile storage is a register array guarded by a self-timed write cycle whose length is a parameter in clock cycles. While that cycle runs, only a status poll of the control register is served. After reset the wipers sit at mid-scale and every access is refused until an external ready input allows the stored start-up codes to be recalled into the wipers.

Top module: `dcp_reg_ctrl`

## Requirements
- R1: After reset both wiper codes are 80h and every request is answered with accept 0 until `recall_ok` is seen high at a clock edge. At that edge each wiper is loaded from its stored start-up code, and requests are served from then on.
- R2: The control register sits at address 10h. It reads back as {vol, run, busy, 000, od, 0}, from bit 7 down to bit 0, and after reset it reads 40h. A write sets vol (bit 7), run (bit 6) and od (bit 1), and ignores the other bits. The `sdo_opendrain` output follows od.
- R3: With vol = 1, addresses 00h and 01h read and write the wiper code of channel 0 and channel 1 directly, and no non-volatile cycle starts.
- R4: With vol = 0, addresses 00h and 01h read the stored start-up code, and such a read leaves the wiper untouched. A write stores the byte as the start-up code, loads the same byte into that channel's wiper and starts a non-volatile cycle.
- R5: With vol = 0, addresses 02h to 0Eh are general-purpose non-volatile bytes that can be read and written. A write starts a non-volatile cycle.
- R6: Writes to 02h–0Eh while vol = 1, and writes to 0Fh or to 11h–1Fh, are accepted but change nothing. Reads of those locations return 00h.
- R7: The busy bit reads 1 for exactly NV_CYCLES consecutive clock cycles after the edge that accepts a non-volatile write. After that it reads 0.
- R8: While busy is 1, only a read of address 10h is accepted. Every other request gets accept 0, data 00h, and has no effect.
- R9: While run = 0, both `shutdown` bits are 1 and both wiper code outputs are 00h. The held wiper codes are kept and can still be written. Setting run back to 1 brings out the held codes again.
- R10: Every request is answered on the clock edge after it is presented, with `rsp_valid` high. A refused request or a write returns data 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (cold start) |
| recall_ok | input | 1 | Allows recall of the start-up codes into the wipers |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_ok | output | 1 | Request was accepted |
| rsp_rdata | output | 8 | Read data (00h when refused or for a write) |
| wiper_code | output | 2x8 | Wiper code per channel, 00h in shutdown |
| shutdown | output | 2 | Shutdown indication per channel |
| sdo_opendrain | output | 1 | Serial data pin output-type selection |

## Verification
Directed sequences walk the block through a cold start with recall held off, direct wiper access, start-up-code access, general-purpose storage, ignored locations and a shutdown round trip. These show whether the vol bit routes the shared low addresses correctly, and whether reading a start-up code wrongly disturbs the wiper. A back-to-back status poll right after a non-volatile write counts the busy cycles exactly, and requests issued in the middle of that window separate the allowed poll from refused accesses. A seeded random run then mixes control writes, ignored addresses and reads while writes keep landing inside busy windows. Each response and each output is compared against a bench model of the register map.

// File: rtl/dcp_regs_pkg.sv
package dcp_regs_pkg;

    localparam int          ADDR_W    = 5;
    localparam logic [4:0]  ACR_ADDR  = 5'h10;
    localparam logic [4:0]  GP_LAST   = 5'h0E;
    localparam int          NV_DEPTH  = 15;

    typedef struct packed {
        logic vol;
        logic run;
        logic od;
    } ctrl_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_WIPER,
        TGT_START,
        TGT_GP
    } tgt_e;

    function automatic tgt_e decode_addr(input logic [ADDR_W-1:0] a,
                                         input logic vol,
                                         input int nch);
        if (a == ACR_ADDR)
            return TGT_CTRL;
        if (int'(a) < nch)
            return vol ? TGT_WIPER : TGT_START;
        if (a <= GP_LAST && !vol)
            return TGT_GP;
        return TGT_NONE;
    endfunction

    function automatic logic [7:0] pack_ctrl(input ctrl_t c, input logic busy);
        return {c.vol, c.run, busy, 3'b000, c.od, 1'b0};
    endfunction

endpackage

// File: rtl/dcp_nv_store.sv
module dcp_nv_store #(
    parameter int          NCH       = 2,
    parameter int          DW        = 8,
    parameter int          DEPTH     = 15,
    parameter int          NV_CYCLES = 2000000,
    parameter logic [NCH*DW-1:0] START_INIT = {NCH{8'h80}},
    localparam int         IW        = $clog2(DEPTH),
    localparam int         CW        = $clog2(NV_CYCLES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [IW-1:0]            rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic [NCH-1:0][DW-1:0]   start_code,
    output logic                     busy
);

    logic [DEPTH-1:0][DW-1:0] cells;
    logic [CW-1:0]            remain_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        if (g < NCH) begin : g_start
            always_ff @(posedge clk) begin
                if (rst)
                    cell_q <= START_INIT[g*DW +: DW];
                else if (wr_en && wr_idx == IW'(g))
                    cell_q <= wr_data;
            end
            assign start_code[g] = cell_q;
        end else begin : g_gp
            always_ff @(posedge clk) begin
                if (rst)
                    cell_q <= '0;
                else if (wr_en && wr_idx == IW'(g))
                    cell_q <= wr_data;
            end
        end
        assign cells[g] = cell_q;
    end

    assign rd_data = (int'(rd_idx) < DEPTH) ? cells[rd_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (wr_en) begin
            busy     <= 1'b1;
            remain_q <= CW'(NV_CYCLES - 1);
        end else if (busy) begin
            if (remain_q == '0)
                busy <= 1'b0;
            else
                remain_q <= remain_q - 1'b1;
        end
    end

    // R7
    nv_start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> busy);

    // R8
    nv_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !busy);

endmodule

// File: rtl/dcp_wiper_bank.sv
module dcp_wiper_bank #(
    parameter int            NCH = 2,
    parameter int            DW  = 8,
    parameter logic [DW-1:0] MID = 8'h80,
    localparam int           CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     recall_ok,
    input  logic [NCH-1:0][DW-1:0]   start_code,
    input  logic                     wr_en,
    input  logic [CHW-1:0]           wr_ch,
    input  logic [DW-1:0]            wr_data,
    input  logic                     run,
    output logic                     recall_done,
    output logic [NCH-1:0][DW-1:0]   held_code,
    output logic [NCH-1:0][DW-1:0]   wiper_code,
    output logic [NCH-1:0]           shutdown
);

    always_ff @(posedge clk) begin
        if (rst)
            recall_done <= 1'b0;
        else if (recall_ok)
            recall_done <= 1'b1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] code_q;
        always_ff @(posedge clk) begin
            if (rst)
                code_q <= MID;
            else if (!recall_done && recall_ok)
                code_q <= start_code[c];
            else if (wr_en && wr_ch == CHW'(c))
                code_q <= wr_data;
        end
        assign held_code[c]  = code_q;
        assign wiper_code[c] = run ? code_q : '0;
        assign shutdown[c]   = ~run;
    end

    // R1
    recall_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(recall_done) |-> held_code == $past(start_code));

    // R1
    mid_until_recall_chk: assert property (@(posedge clk) disable iff (rst)
        (!recall_done && !$past(recall_ok)) |-> held_code == {NCH{MID}});

endmodule

// File: rtl/dcp_reg_ctrl.sv
module dcp_reg_ctrl
    import dcp_regs_pkg::*;
#(
    parameter int                NCH        = 2,
    parameter int                DW         = 8,
    parameter int                NV_CYCLES  = 2000000,
    parameter logic [NCH*DW-1:0] START_INIT = {NCH{8'h80}},
    localparam int               IW         = $clog2(NV_DEPTH),
    localparam int               CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     recall_ok,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DW-1:0]            req_wdata,
    output logic                     rsp_valid,
    output logic                     rsp_ok,
    output logic [DW-1:0]            rsp_rdata,
    output logic [NCH-1:0][DW-1:0]   wiper_code,
    output logic [NCH-1:0]           shutdown,
    output logic                     sdo_opendrain
);

    ctrl_t                   ctrl_q;
    tgt_e                    tgt;
    logic                    nv_busy;
    logic                    recall_done;
    logic                    allow;
    logic                    do_write;
    logic                    ctrl_wr;
    logic                    wiper_wr;
    logic                    nv_wr;
    logic [DW-1:0]           nv_rdata;
    logic [DW-1:0]           rd_mux;
    logic [NCH-1:0][DW-1:0]  start_code;
    logic [NCH-1:0][DW-1:0]  held_code;

    assign tgt      = decode_addr(req_addr, ctrl_q.vol, NCH);
    assign allow    = req_valid && recall_done &&
                      (!nv_busy || (!req_write && tgt == TGT_CTRL));
    assign do_write = allow && req_write;
    assign ctrl_wr  = do_write && tgt == TGT_CTRL;
    assign wiper_wr = do_write && (tgt == TGT_WIPER || tgt == TGT_START);
    assign nv_wr    = do_write && (tgt == TGT_START || tgt == TGT_GP);

    always_comb begin
        unique case (tgt)
            TGT_CTRL:            rd_mux = pack_ctrl(ctrl_q, nv_busy);
            TGT_WIPER:           rd_mux = held_code[req_addr[CHW-1:0]];
            TGT_START, TGT_GP:   rd_mux = nv_rdata;
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{vol: 1'b0, run: 1'b1, od: 1'b0};
        end else if (ctrl_wr) begin
            ctrl_q <= '{vol: req_wdata[7], run: req_wdata[6], od: req_wdata[1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= allow;
            rsp_rdata <= (allow && !req_write) ? rd_mux : '0;
        end
    end

    assign sdo_opendrain = ctrl_q.od;

    dcp_nv_store #(
        .NCH        (NCH),
        .DW         (DW),
        .DEPTH      (NV_DEPTH),
        .NV_CYCLES  (NV_CYCLES),
        .START_INIT (START_INIT)
    ) u_nv (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (nv_wr),
        .wr_idx     (req_addr[IW-1:0]),
        .wr_data    (req_wdata),
        .rd_idx     (req_addr[IW-1:0]),
        .rd_data    (nv_rdata),
        .start_code (start_code),
        .busy       (nv_busy)
    );

    dcp_wiper_bank #(
        .NCH (NCH),
        .DW  (DW),
        .MID (8'h80)
    ) u_wipers (
        .clk         (clk),
        .rst         (rst),
        .recall_ok   (recall_ok),
        .start_code  (start_code),
        .wr_en       (wiper_wr),
        .wr_ch       (req_addr[CHW-1:0]),
        .wr_data     (req_wdata),
        .run         (ctrl_q.run),
        .recall_done (recall_done),
        .held_code   (held_code),
        .wiper_code  (wiper_code),
        .shutdown    (shutdown)
    );

    // R8
    busy_lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && nv_busy && (req_write || req_addr != ACR_ADDR)) |=> !rsp_ok);

    // R1
    recall_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !recall_done) |=> !rsp_ok);

    // R10
    refused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_ok |-> rsp_rdata == '0);

    // R3
    direct_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && recall_done && !nv_busy && ctrl_q.vol &&
         int'(req_addr) < NCH) |=> !nv_busy);

endmodule

// File: tb/dcp_reg_ctrl_tb.sv
module dcp_reg_ctrl_tb;

    localparam int NCH    = 2;
    localparam int DW     = 8;
    localparam int NVC    = 12;
    localparam logic [15:0] INIT = {8'hC0, 8'h3A};

    logic clk = 1'b0;
    logic rst;
    logic recall_ok;
    logic req_valid;
    logic req_write;
    logic [4:0] req_addr;
    logic [7:0] req_wdata;
    logic rsp_valid;
    logic rsp_ok;
    logic [7:0] rsp_rdata;
    logic [NCH-1:0][DW-1:0] wiper_code;
    logic [NCH-1:0] shutdown;
    logic sdo_opendrain;

    always #2.5 clk = ~clk;

    dcp_reg_ctrl #(.NCH(NCH), .DW(DW), .NV_CYCLES(NVC), .START_INIT(INIT)) u_dut (
        .clk(clk), .rst(rst), .recall_ok(recall_ok),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_rdata(rsp_rdata), .wiper_code(wiper_code), .shutdown(shutdown),
        .sdo_opendrain(sdo_opendrain)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model of the register map
    logic [7:0] m_nv [15];
    logic [7:0] m_w  [2];
    bit m_vol, m_run, m_od, m_ready;
    int m_bcnt;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input bit wr, input logic [4:0] a);
        if (!m_ready) return "R1";
        if (m_bcnt > 0) return (!wr && a == 5'h10) ? "R7" : "R8";
        if (a == 5'h10) return "R2";
        if (a < 5'd2) return m_vol ? "R3" : "R4";
        if (a <= 5'h0E && !m_vol) return "R5";
        return "R6";
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        if (a == 5'h10) return {m_vol, m_run, (m_bcnt > 0), 3'b000, m_od, 1'b0};
        if (a < 5'd2) return m_vol ? m_w[a[0]] : m_nv[a];
        if (a <= 5'h0E && !m_vol) return m_nv[a];
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 15; i++) m_nv[i] = 8'h00;
        m_nv[0] = INIT[7:0];
        m_nv[1] = INIT[15:8];
        m_w[0] = 8'h80;
        m_w[1] = 8'h80;
        m_vol = 0; m_run = 1; m_od = 0; m_ready = 0; m_bcnt = 0;
    endtask

    task automatic do_req(input bit v, input bit wr, input logic [4:0] a, input logic [7:0] d);
        bit allow, rec;
        logic [7:0] erd;
        string tag;
        @(negedge clk);
        req_valid = v; req_write = wr; req_addr = a; req_wdata = d;
        tag = tag_of(wr, a);
        rec = recall_ok;
        allow = v && m_ready && (m_bcnt == 0 || (!wr && a == 5'h10));
        erd = (allow && !wr) ? exp_read(a) : 8'h00;
        @(posedge clk);
        #1;
        req_valid = 0;
        if (m_bcnt > 0) m_bcnt--;
        if (!m_ready && rec) begin
            m_ready = 1;
            m_w[0] = m_nv[0];
            m_w[1] = m_nv[1];
        end
        if (allow && wr) begin
            if (a == 5'h10) begin
                m_vol = d[7]; m_run = d[6]; m_od = d[1];
            end else if (a < 5'd2) begin
                m_w[a[0]] = d;
                if (!m_vol) begin m_nv[a] = d; m_bcnt = NVC; end
            end else if (a <= 5'h0E && !m_vol) begin
                m_nv[a] = d; m_bcnt = NVC;
            end
        end
        chk(rsp_valid == v, "R10", rsp_valid, v);
        if (v) begin
            chk(rsp_ok == allow, tag, rsp_ok, allow);
            chk(rsp_rdata == erd, tag, rsp_rdata, erd);
        end
        chk(wiper_code[0] == (m_run ? m_w[0] : 8'h00), m_run ? tag : "R9", wiper_code[0], m_run ? m_w[0] : 8'h00);
        chk(wiper_code[1] == (m_run ? m_w[1] : 8'h00), m_run ? tag : "R9", wiper_code[1], m_run ? m_w[1] : 8'h00);
        chk(shutdown == {2{~m_run}}, "R9", shutdown, {2{~m_run}});
        chk(sdo_opendrain == m_od, "R2", sdo_opendrain, m_od);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int wip_ones;
        void'($urandom(32'h5EED));
        rst = 1; recall_ok = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: mid-scale and refusal before recall
        do_req(1, 0, 5'h10, 8'h00);
        do_req(1, 1, 5'h00, 8'h11);
        chk(wiper_code[0] == 8'h80, "R1", wiper_code[0], 8'h80);
        @(negedge clk); recall_ok = 1;
        do_req(0, 0, 5'h00, 8'h00);
        chk(wiper_code[0] == 8'h3A && wiper_code[1] == 8'hC0, "R1", wiper_code, 16'hC03A);

        // R2: control register
        do_req(1, 0, 5'h10, 8'h00);
        chk(rsp_rdata == 8'h40, "R2", rsp_rdata, 8'h40);
        do_req(1, 1, 5'h10, 8'hBF);
        do_req(1, 0, 5'h10, 8'h00);
        chk(rsp_rdata == 8'h82, "R2", rsp_rdata, 8'h82);

        // R3: direct wiper access
        do_req(1, 1, 5'h00, 8'h55);
        do_req(1, 0, 5'h10, 8'h00);
        do_req(1, 0, 5'h01, 8'h00);

        // R4: start-up code access
        do_req(1, 1, 5'h10, 8'h40);
        do_req(1, 0, 5'h00, 8'h00);
        chk(wiper_code[0] == 8'h55, "R4", wiper_code[0], 8'h55);
        do_req(1, 1, 5'h01, 8'h9D);
        // R7: count busy polls
        wip_ones = 0;
        for (int i = 0; i < NVC + 3; i++) begin
            do_req(1, 0, 5'h10, 8'h00);
            if (rsp_rdata[5]) wip_ones++;
        end
        chk(wip_ones == NVC, "R7", wip_ones, NVC);

        // R5 and R8: general purpose write, lockout during busy
        do_req(1, 1, 5'h05, 8'hA5);
        do_req(1, 0, 5'h05, 8'h00);
        do_req(1, 1, 5'h10, 8'h80);
        do_req(1, 1, 5'h00, 8'h01);
        for (int i = 0; i < NVC; i++) do_req(1, 0, 5'h10, 8'h00);
        do_req(1, 0, 5'h05, 8'h00);
        chk(rsp_rdata == 8'hA5, "R5", rsp_rdata, 8'hA5);

        // R6: ignored locations
        do_req(1, 1, 5'h10, 8'h80);
        do_req(1, 1, 5'h07, 8'h77);
        do_req(1, 0, 5'h07, 8'h00);
        do_req(1, 1, 5'h0F, 8'h66);
        do_req(1, 0, 5'h0F, 8'h00);
        do_req(1, 1, 5'h13, 8'h44);
        do_req(1, 0, 5'h13, 8'h00);
        do_req(1, 1, 5'h10, 8'h40);
        do_req(1, 0, 5'h07, 8'h00);
        chk(rsp_rdata == 8'h00, "R6", rsp_rdata, 8'h00);

        // R9: shutdown round trip
        do_req(1, 1, 5'h10, 8'h00);
        do_req(1, 1, 5'h10, 8'h80);
        do_req(1, 1, 5'h00, 8'h22);
        do_req(1, 1, 5'h10, 8'hC0);
        chk(wiper_code[0] == 8'h22 && wiper_code[1] == 8'h9D, "R9", wiper_code, 16'h9D22);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [4:0] a;
            int sel = $urandom_range(0, 9);
            case (sel)
                0, 1:    a = 5'h10;
                2, 3, 4: a = 5'($urandom_range(0, 1));
                5, 6:    a = 5'($urandom_range(2, 14));
                7:       a = 5'h0F;
                default: a = 5'($urandom_range(0, 31));
            endcase
            do_req($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a, 8'($urandom));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule